// File: doc/BRIEF.md
# NAND Bad-Block Remap Manager

This block owns the logical-to-physical block map of a NAND array. The array is split into two partitions. The low partition holds the user blocks. The high partition is a reserve of substitute blocks. The manager reaches the flash only through a small request port. On that port it can do three things: read the first spare-area byte of a block's first page, read the 48-bit remap marker stored there, or write such a marker. Moving page data, computing ECC and driving the flash pins are left to other logic.

After reset the manager builds the map and holds `busy` high while it works. It first reads the marker of the lowest reserve block.
- If that marker carries the magic tag, the device is already formatted. The manager walks the reserve partition and rebuilds the map from the back-pointers it finds there.
- Otherwise the device is fresh. The manager tests every user block, gives each bad one the next good reserve block, and records the choice by writing a marker into the substitute block.
- If a fresh device has no bad block at all, the manager writes a null marker so that the device is seen as formatted at the next start.

Once `busy` falls, a logical block number can be presented on the lookup port. The physical block number comes back one cycle later.

Top module: `nand_remap_mgr`

## Requirements
- R1: While reset is asserted and until the first request completes, `busy` is 1. During that time `lk_ack`, `exhausted` and `write_err` are 0.
- R2: A lookup made while `busy` is 1 gets no `lk_ack`. Flash requests are issued only while `busy` is 1. `busy` falls once initialisation ends and stays low until the next reset.
- R3: With `busy` low, a lookup with `lk_blk` below USER_BLKS raises `lk_ack` for one cycle, in the cycle after `lk_req`. In that cycle `lk_phys` holds the mapped block, and a block that was never redirected maps to itself. A lookup with `lk_blk` at or above USER_BLKS gets no `lk_ack`.
- R4: The request opcode is `fl_req_op`: 0 reads the spare byte, 1 reads the marker, 2 writes a marker. For a spare read the byte is returned in `fl_rsp_rdata[7:0]`. A block is good only when that byte is 8'hFF; any other value makes it bad.
- R5: A marker is 48 bits. Bits [47:16] hold the tag 32'h5EB10C4D and bits [15:0] hold the index of the user block being replaced. Every marker write carries that tag, and the null index is 16'hFFFF.
- R6: The first request after reset reads the marker of block USER_BLKS. If it carries the tag, no marker is written during initialisation and no user block is tested.
- R7: On a formatted device, a reserve block redirects user block k to itself only if all of the following hold: its spare byte marks it good, its marker carries the tag, and k is neither the null index nor at or above USER_BLKS. Markers found on bad reserve blocks are ignored.
- R8: On a fresh device, user blocks are tested in ascending order. Each bad one receives the lowest good reserve block not yet used, and bad reserve blocks are skipped. Each such choice is recorded by writing a marker that names the bad user block into the substitute block.
- R9: If a fresh device has no bad user block, exactly one marker is written: the null index to block USER_BLKS.
- R10: When the reserve partition has no good block left for a bad user block, `exhausted` rises and stays high until reset. That user block keeps mapping to itself, and no marker is written for it.
- R11: A marker write completed with `fl_rsp_wr_ok` = 0 sets `write_err`, which stays high until reset.
- R12: At most one request is outstanding at a time. `fl_req_valid`, `fl_req_op`, `fl_req_blk` and `fl_req_wdata` stay stable until `fl_req_ready`, and `fl_req_valid` is low while the manager waits for `fl_rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup strobe |
| lk_blk | input | 16 | Logical block to look up |
| lk_ack | output | 1 | Lookup answered (one cycle after lk_req) |
| lk_phys | output | 16 | Physical block for the answered lookup |
| busy | output | 1 | Initialisation in progress, lookups refused |
| exhausted | output | 1 | Sticky: reserve partition ran out of good blocks |
| write_err | output | 1 | Sticky: a marker write reported failure |
| fl_req_valid | output | 1 | Flash request valid |
| fl_req_ready | input | 1 | Flash request accepted |
| fl_req_op | output | 2 | 0 spare read, 1 marker read, 2 marker write |
| fl_req_blk | output | 16 | Target block (first page) |
| fl_req_wdata | output | 48 | Marker to write |
| fl_rsp_done | input | 1 | One-cycle completion pulse |
| fl_rsp_rdata | input | 48 | Read data (spare byte in [7:0], or marker) |
| fl_rsp_wr_ok | input | 1 | Write status with the done pulse |

## Verification
The situations hardest to reach from the ports are three:
- a stale marker sitting on a reserve block that is itself bad;
- the reserve running dry halfway through a fresh-device scan;
- the null-marker path.

Each needs a particular flash image, because the manager sees the flash only through its request port. The bench therefore answers every request from its own model of spare bytes and markers. That model is preloaded under reset for each scenario and logs every marker write. A scenario can then exercise exhaustion by marking more user blocks bad than there are reserve blocks. It can plant tagged, mistagged, out-of-range and null markers, some of them on bad blocks.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int BLK_W  = 16;
  localparam int MARK_W = 48;
  localparam logic [31:0] MARK_TAG = 32'h5EB1_0C4D;
  localparam logic [15:0] NULL_IDX = 16'hFFFF;

  typedef enum logic [1:0] {
    OP_RD_SPARE = 2'd0,
    OP_RD_MARK  = 2'd1,
    OP_WR_MARK  = 2'd2
  } fl_op_e;

  function automatic logic spare_good(input logic [7:0] b);
    return b == 8'hFF;
  endfunction

  function automatic logic mark_tagged(input logic [MARK_W-1:0] m);
    return m[47:16] == MARK_TAG;
  endfunction

  function automatic logic [BLK_W-1:0] mark_index(input logic [MARK_W-1:0] m);
    return m[15:0];
  endfunction

  function automatic logic [MARK_W-1:0] make_mark(input logic [BLK_W-1:0] idx);
    return {MARK_TAG, idx};
  endfunction
endpackage

// File: rtl/remap_table.sv
module remap_table
  import remap_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [BLK_W-1:0] waddr,
  input  logic [BLK_W-1:0] wdata,
  input  logic [BLK_W-1:0] raddr,
  output logic [BLK_W-1:0] rdata
);
  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [BLK_W-1:0] mem [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                          mem[i] <= BLK_W'(i);
      else if (we && waddr == BLK_W'(i))   mem[i] <= wdata;
    end
  end

  always_comb begin
    if (raddr < BLK_W'(ENTRIES)) rdata = mem[raddr[AW-1:0]];
    else                         rdata = '0;
  end

  assert_write_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> waddr < BLK_W'(ENTRIES));
endmodule

// File: rtl/flash_req_agent.sv
module flash_req_agent
  import remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_in,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic [MARK_W-1:0] wdata_in,
  output logic              fl_req_valid,
  input  logic              fl_req_ready,
  output logic [1:0]        fl_req_op,
  output logic [BLK_W-1:0]  fl_req_blk,
  output logic [MARK_W-1:0] fl_req_wdata,
  input  logic              fl_rsp_done,
  output logic              got
);
  typedef enum logic [1:0] {A_IDLE, A_REQ, A_WAIT} ast_e;
  ast_e st;

  assign fl_req_valid = (st == A_REQ);
  assign got          = (st == A_WAIT) && fl_rsp_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= A_IDLE;
      fl_req_op    <= '0;
      fl_req_blk   <= '0;
      fl_req_wdata <= '0;
    end else begin
      unique case (st)
        A_IDLE: if (start) begin
          st           <= A_REQ;
          fl_req_op    <= op_in;
          fl_req_blk   <= blk_in;
          fl_req_wdata <= wdata_in;
        end
        A_REQ:  if (fl_req_ready) st <= A_WAIT;
        A_WAIT: if (fl_rsp_done)  st <= A_IDLE;
        default: st <= A_IDLE;
      endcase
    end
  end

  assert_hold_until_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid && !fl_req_ready |=> fl_req_valid && $stable(fl_req_blk)
      && $stable(fl_req_op) && $stable(fl_req_wdata));

  assert_write_tagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid && fl_req_op == OP_WR_MARK |-> mark_tagged(fl_req_wdata));

  assert_no_start_while_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    st != A_IDLE |-> !start);
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int USER_BLKS  = 16,
  parameter int TOTAL_BLKS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              start,
  output logic [1:0]        op,
  output logic [BLK_W-1:0]  blk,
  output logic [MARK_W-1:0] wdata,
  input  logic              got,
  input  logic [MARK_W-1:0] rdata,
  input  logic              wr_ok,
  output logic              map_we,
  output logic [BLK_W-1:0]  map_waddr,
  output logic [BLK_W-1:0]  map_wdata,
  output logic              busy,
  output logic              exhausted,
  output logic              write_err
);
  localparam logic [BLK_W-1:0] USER_B  = BLK_W'(USER_BLKS);
  localparam logic [BLK_W-1:0] TOTAL_B = BLK_W'(TOTAL_BLKS);

  typedef enum logic [2:0] {
    S_FMT, S_FSPR, S_FMRK, S_USPR, S_ASPR, S_AWR, S_NULLWR, S_DONE
  } cst_e;

  cst_e             st;
  logic [BLK_W-1:0] cur_b, ptr, last;
  logic             issued, any_bad;

  // named internal events
  logic good_rsp, redirect_ok, ptr_end, u_last, f_last;
  assign good_rsp    = spare_good(rdata[7:0]);
  assign redirect_ok = mark_tagged(rdata) && mark_index(rdata) != NULL_IDX
                       && mark_index(rdata) < USER_B;
  assign ptr_end     = ptr >= TOTAL_B;
  assign u_last      = cur_b == USER_B - 1'b1;
  assign f_last      = cur_b == TOTAL_B - 1'b1;
  assign busy        = st != S_DONE;

  always_comb begin
    op    = OP_RD_SPARE;
    blk   = cur_b;
    wdata = '0;
    unique case (st)
      S_FMT:    begin op = OP_RD_MARK;  blk = USER_B; end
      S_FMRK:   op = OP_RD_MARK;
      S_ASPR:   blk = ptr;
      S_AWR:    begin op = OP_WR_MARK; blk = ptr; wdata = make_mark(cur_b); end
      S_NULLWR: begin op = OP_WR_MARK; blk = USER_B; wdata = make_mark(NULL_IDX); end
      default:  ;
    endcase
    start = busy && !issued && !(st == S_ASPR && ptr_end);
  end

  always_comb begin
    map_we    = 1'b0;
    map_waddr = cur_b;
    map_wdata = cur_b;
    if (got && st == S_FMRK && redirect_ok) begin
      map_we    = 1'b1;
      map_waddr = mark_index(rdata);
    end else if (got && st == S_ASPR && good_rsp) begin
      map_we    = 1'b1;
      map_wdata = ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FMT; cur_b <= '0; ptr <= USER_B; last <= USER_B;
      issued <= 1'b0; any_bad <= 1'b0; exhausted <= 1'b0; write_err <= 1'b0;
    end else begin
      if (got)        issued <= 1'b0;
      else if (start) issued <= 1'b1;
      unique case (st)
        S_FMT: if (got) begin
          if (mark_tagged(rdata)) begin st <= S_FSPR; cur_b <= USER_B; end
          else                    begin st <= S_USPR; cur_b <= '0;     end
        end
        S_FSPR, S_FMRK: if (got) begin
          if (st == S_FSPR && good_rsp) st <= S_FMRK;
          else begin
            if (st == S_FMRK && redirect_ok) last <= cur_b + 1'b1;
            if (f_last) begin
              st  <= S_DONE;
              ptr <= (st == S_FMRK && redirect_ok) ? cur_b + 1'b1 : last;
            end else begin
              st <= S_FSPR; cur_b <= cur_b + 1'b1;
            end
          end
        end
        S_USPR: if (got) begin
          if (!good_rsp) begin any_bad <= 1'b1; st <= S_ASPR; end
          else if (u_last) st <= any_bad ? S_DONE : S_NULLWR;
          else cur_b <= cur_b + 1'b1;
        end
        S_ASPR: begin
          if (ptr_end && !issued) begin
            exhausted <= 1'b1;
            if (u_last) st <= S_DONE;
            else begin st <= S_USPR; cur_b <= cur_b + 1'b1; end
          end else if (got) begin
            if (good_rsp) st <= S_AWR;
            else          ptr <= ptr + 1'b1;
          end
        end
        S_AWR: if (got) begin
          if (!wr_ok) write_err <= 1'b1;
          ptr <= ptr + 1'b1;
          if (u_last) st <= S_DONE;
          else begin st <= S_USPR; cur_b <= cur_b + 1'b1; end
        end
        S_NULLWR: if (got) begin
          if (!wr_ok) write_err <= 1'b1;
          st <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  assert_exhausted_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |=> exhausted);
  assert_write_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    write_err |=> write_err);
  assert_map_target_reserve_R8: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> map_wdata >= USER_B && map_wdata < TOTAL_B);
  assert_done_is_final_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
endmodule

// File: rtl/nand_remap_mgr.sv
module nand_remap_mgr
  import remap_pkg::*;
#(
  parameter int USER_BLKS  = 16,
  parameter int TOTAL_BLKS = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_req,
  input  logic [15:0] lk_blk,
  output logic        lk_ack,
  output logic [15:0] lk_phys,
  output logic        busy,
  output logic        exhausted,
  output logic        write_err,
  output logic        fl_req_valid,
  input  logic        fl_req_ready,
  output logic [1:0]  fl_req_op,
  output logic [15:0] fl_req_blk,
  output logic [47:0] fl_req_wdata,
  input  logic        fl_rsp_done,
  input  logic [47:0] fl_rsp_rdata,
  input  logic        fl_rsp_wr_ok
);
  logic              start, got, map_we;
  logic [1:0]        c_op;
  logic [BLK_W-1:0]  c_blk, map_waddr, map_wdata, map_rdata;
  logic [MARK_W-1:0] c_wdata;

  remap_ctrl #(.USER_BLKS(USER_BLKS), .TOTAL_BLKS(TOTAL_BLKS)) u_ctrl (
    .clk, .rst_n, .start, .op(c_op), .blk(c_blk), .wdata(c_wdata),
    .got, .rdata(fl_rsp_rdata), .wr_ok(fl_rsp_wr_ok),
    .map_we, .map_waddr, .map_wdata, .busy, .exhausted, .write_err);

  flash_req_agent u_agent (
    .clk, .rst_n, .start, .op_in(c_op), .blk_in(c_blk), .wdata_in(c_wdata),
    .fl_req_valid, .fl_req_ready, .fl_req_op, .fl_req_blk, .fl_req_wdata,
    .fl_rsp_done, .got);

  remap_table #(.ENTRIES(USER_BLKS)) u_table (
    .clk, .rst_n, .we(map_we), .waddr(map_waddr), .wdata(map_wdata),
    .raddr(lk_blk), .rdata(map_rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_ack  <= 1'b0;
      lk_phys <= '0;
    end else begin
      lk_ack  <= lk_req && !busy && lk_blk < BLK_W'(USER_BLKS);
      lk_phys <= map_rdata;
    end
  end

  assert_no_ack_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ack |-> !$past(busy));
  assert_req_only_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid |-> busy);
  assert_ack_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ack |-> $past(lk_req) && $past(lk_blk) < BLK_W'(USER_BLKS));
endmodule

// File: tb/nand_remap_mgr_bench.sv
module nand_remap_mgr_bench;
  localparam int USER  = 16;
  localparam int TOTAL = 24;
  localparam logic [31:0] TAG = 32'h5EB1_0C4D;

  logic        clk = 0, rst_n = 0;
  logic        lk_req = 0;
  logic [15:0] lk_blk = 0;
  logic        lk_ack, busy, exhausted, write_err;
  logic [15:0] lk_phys;
  logic        fl_req_valid, fl_req_ready = 0;
  logic [1:0]  fl_req_op;
  logic [15:0] fl_req_blk;
  logic [47:0] fl_req_wdata;
  logic        fl_rsp_done = 0, fl_rsp_wr_ok = 0;
  logic [47:0] fl_rsp_rdata = 0;

  int checks = 0, errors = 0, hs_bad = 0, wr_cnt = 0, rd_cnt = 0;
  logic [7:0]  spare [TOTAL];
  logic [47:0] mark  [TOTAL];
  logic [15:0] wr_blk [32];
  logic [47:0] wr_dat [32];
  logic [1:0]  first_op;
  logic [15:0] first_blk;
  logic        fail_wr = 0;

  nand_remap_mgr #(.USER_BLKS(USER), .TOTAL_BLKS(TOTAL)) u_nand_remap_mgr (.*);

  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model answering requests
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && fl_req_valid) begin
        logic [1:0] op; logic [15:0] b; logic [47:0] d;
        op = fl_req_op; b = fl_req_blk; d = fl_req_wdata;
        if (rd_cnt == 0) begin first_op = op; first_blk = b; end
        rd_cnt++;
        @(negedge clk);
        if (!fl_req_valid || fl_req_blk != b || fl_req_op != op || fl_req_wdata != d) hs_bad++;
        fl_req_ready = 1;
        @(negedge clk);
        fl_req_ready = 0;
        if (fl_req_valid) hs_bad++;
        @(negedge clk);
        if (fl_req_valid) hs_bad++;
        fl_rsp_wr_ok = 0;
        if (b >= TOTAL) fl_rsp_rdata = '0;
        else if (op == 2'd0) fl_rsp_rdata = {40'h0, spare[b]};
        else if (op == 2'd1) fl_rsp_rdata = mark[b];
        else begin
          if (!fail_wr) mark[b] = d;
          fl_rsp_wr_ok = !fail_wr;
          if (wr_cnt < 32) begin wr_blk[wr_cnt] = b; wr_dat[wr_cnt] = d; end
          wr_cnt++;
        end
        fl_rsp_done = 1;
        @(negedge clk);
        fl_rsp_done = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic blank_flash();
    for (int i = 0; i < TOTAL; i++) begin spare[i] = 8'hFF; mark[i] = '1; end
    wr_cnt = 0; rd_cnt = 0; fail_wr = 0;
  endtask

  task automatic start_init();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_init();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic look(input int b, input int exp, input string req);
    @(negedge clk); lk_req = 1; lk_blk = 16'(b);
    @(negedge clk); lk_req = 0;
    chk(lk_ack === 1'b1 && lk_phys == 16'(exp), req, {lk_ack, lk_phys}, {1'b1, 16'(exp)});
  endtask

  task automatic test_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1 && lk_ack === 0 && exhausted === 0 && write_err === 0, "R1 reset state",
        {busy, lk_ack, exhausted, write_err}, 4'b1000);
  endtask

  task automatic test_clean();
    blank_flash();
    start_init();
    @(negedge clk); lk_req = 1; lk_blk = 16'd2;
    @(negedge clk); lk_req = 0;
    chk(lk_ack === 0 && busy === 1, "R2 lookup refused while busy", {busy, lk_ack}, 2'b10);
    wait_init();
    chk(busy === 0, "R2 busy falls", busy, 0);
    chk(first_op == 2'd1 && first_blk == 16'(USER), "R6 first request reads reserve marker",
        {first_op, first_blk}, {2'd1, 16'(USER)});
    chk(wr_cnt == 1 && wr_blk[0] == 16'(USER) && wr_dat[0] == {TAG, 16'hFFFF},
        "R9 null marker written", wr_dat[0], {TAG, 16'hFFFF});
    look(0, 0, "R3 identity block 0");
    look(USER-1, USER-1, "R3 identity last user block");
    @(negedge clk); lk_req = 1; lk_blk = 16'(USER);
    @(negedge clk); lk_req = 0;
    chk(lk_ack === 0, "R3 out-of-range lookup refused", lk_ack, 0);
    chk(exhausted === 0 && write_err === 0, "R10 R11 flags clear", {exhausted, write_err}, 0);
  endtask

  task automatic test_bad();
    blank_flash();
    spare[3] = 8'h00; spare[7] = 8'hF0; spare[USER] = 8'h00;
    start_init(); wait_init();
    chk(wr_cnt == 2, "R8 two markers written", wr_cnt, 2);
    chk(wr_blk[0] == 16'(USER+1) && wr_dat[0] == {TAG, 16'd3}, "R8 first marker",
        {wr_blk[0], wr_dat[0]}, {16'(USER+1), TAG, 16'd3});
    chk(wr_blk[1] == 16'(USER+2) && wr_dat[1] == {TAG, 16'd7}, "R8 second marker",
        {wr_blk[1], wr_dat[1]}, {16'(USER+2), TAG, 16'd7});
    look(3, USER+1, "R4 R8 block 3 remapped, bad reserve skipped");
    look(7, USER+2, "R4 R8 block 7 remapped (0xF0 bad)");
    look(4, 4, "R3 good block unchanged");
  endtask

  task automatic test_formatted();
    blank_flash();
    mark[USER]   = {TAG, 16'hFFFF};
    mark[USER+2] = {TAG, 16'd5};
    spare[USER+3] = 8'h00; mark[USER+3] = {TAG, 16'd9};
    mark[USER+4] = {TAG, 16'd11};
    mark[USER+5] = {32'h1234_5678, 16'd2};
    mark[USER+6] = {TAG, 16'd40};
    spare[4] = 8'h00;
    start_init(); wait_init();
    chk(wr_cnt == 0, "R6 no writes on formatted device", wr_cnt, 0);
    look(5, USER+2, "R7 block 5 restored");
    look(11, USER+4, "R7 block 11 restored");
    look(9, 9, "R7 marker on bad block ignored");
    look(2, 2, "R7 mistagged marker ignored");
    look(4, 4, "R6 user block not tested");
  endtask

  task automatic test_exhaust();
    blank_flash();
    for (int i = 0; i < 9; i++) spare[i] = 8'h00;
    spare[USER+1] = 8'h00;
    start_init(); wait_init();
    chk(exhausted === 1, "R10 exhausted raised", exhausted, 1);
    chk(wr_cnt == 7, "R10 no marker for unserved blocks", wr_cnt, 7);
    look(0, USER, "R8 block 0 to first reserve");
    look(1, USER+2, "R8 block 1 skips bad reserve");
    look(6, USER+7, "R8 block 6 gets last reserve");
    look(7, 7, "R10 block 7 keeps identity");
    look(8, 8, "R10 block 8 keeps identity");
    repeat (5) @(negedge clk);
    chk(exhausted === 1, "R10 exhausted sticky", exhausted, 1);
  endtask

  task automatic test_wr_fail();
    blank_flash();
    fail_wr = 1;
    start_init(); wait_init();
    chk(write_err === 1, "R11 write failure flagged", write_err, 1);
    repeat (5) @(negedge clk);
    chk(write_err === 1, "R11 write_err sticky", write_err, 1);
  endtask

  initial begin
    test_reset();
    test_clean();
    test_bad();
    test_formatted();
    test_exhaust();
    test_wr_fail();
    chk(hs_bad == 0, "R12 handshake held and single outstanding", hs_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule